// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sleep and Wake-up

This block receives asynchronous serial characters framed by one low start bit and one high stop bit, carrying either eight or nine data bits sent least significant bit first. A 16x sample enable from outside sets the bit timing. The block decides each bit by a three-sample majority vote near mid-bit. It reports each character with a one-cycle ready pulse and flags a stop bit that is sampled low.

A selector in front of the receiver picks its serial source. The source can be the external receive pin, the transmitter's internal serial output (an internal loopback that bypasses every pin), or the shared transmit pin (single-wire operation). Software can put the receiver to sleep. While it sleeps, characters are not reported. It wakes either on an idle line or on a character whose last data bit is 1 (an address mark).

Idle-line detection counts consecutive 1 bits up to one full character time: 10 bit times for the 8-bit format and 11 for the 9-bit format. In the short variant, counting begins right after the start bit, so trailing 1 data bits and the stop bit count. In the long variant, counting begins only after the stop bit.

Top module: `uwr_rx_wake`

## Requirements
- R1: With `loop_en`=0 the receiver takes its serial input from `rx_pin`. `tx_pin` and `tx_int` have no effect on it.
- R2: With `loop_en`=1 and `rx_src`=0 the receiver takes its input from `tx_int`. `rx_pin` and `tx_pin` are ignored.
- R3: With `loop_en`=1 and `rx_src`=1 the receiver takes its input from `tx_pin`. `rx_pin` and `tx_int` are ignored.
- R4: With `nine_bit`=0 a frame has 1 start bit, 8 data bits (LSB first) and 1 stop bit. The byte appears in `rx_data[7:0]` and `rx_data[8]` reads 0.
- R5: With `nine_bit`=1 a frame has 1 start bit, 9 data bits (LSB first) and 1 stop bit. The ninth bit appears in `rx_data[8]`.
- R6: Each bit is the majority of the 16x samples with indices 6, 7 and 8 counted from the first low start sample. A single wrong sample among them does not change the bit. A start bit that votes 1 is discarded and produces no `data_rdy`.
- R7: A stop bit that votes 0 delivers the character with `frame_err`=1 in the same cycle as `data_rdy`. Otherwise `frame_err`=0.
- R8: With `idle_long`=0, counting of 1 bits starts at the first data bit. Data 1s, the stop bit and idle bit times all count, and a 0 bit clears the count. `idle_det` pulses for one cycle when the count reaches 10 (8-bit) or 11 (9-bit). It pulses at most once per idle period that follows an accepted start bit.
- R9: With `idle_long`=1, only bit times after the stop bit count. `idle_det` pulses exactly 10 (8-bit) or 11 (9-bit) bit times after the stop-bit decision.
- R10: A one-cycle `sleep_req` sets `asleep` on the next clock. While `asleep`=1, a received character does not pulse `data_rdy` unless R12 wakes the receiver.
- R11: With `wake_addr`=0, an `idle_det` pulse clears `asleep`, and the following characters are delivered.
- R12: With `wake_addr`=1, only a character whose last data bit is 1 clears `asleep`. The last data bit is bit 7 in the 8-bit format and bit 8 in the 9-bit format. That character is delivered with `data_rdy`. Characters whose last data bit is 0, and idle lines, leave the receiver asleep.
- R13: After reset `data_rdy`, `idle_det`, `frame_err` and `asleep` are 0 and `rx_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| samp_en | input | 1 | 16x oversampling enable |
| rx_pin | input | 1 | External receive pin level |
| tx_pin | input | 1 | Level on the shared transmit pin |
| tx_int | input | 1 | Transmitter internal serial output |
| loop_en | input | 1 | Selects the loop or single-wire source |
| rx_src | input | 1 | Under loop: 0 internal transmitter, 1 transmit pin |
| nine_bit | input | 1 | 0: 8 data bits, 1: 9 data bits |
| wake_addr | input | 1 | 0: wake on idle line, 1: wake on address mark |
| idle_long | input | 1 | 0: short idle count, 1: long idle count |
| sleep_req | input | 1 | Pulse that puts the receiver to sleep |
| rx_data | output | 9 | Last delivered character |
| data_rdy | output | 1 | One-cycle pulse per delivered character |
| idle_det | output | 1 | One-cycle pulse on idle-line detection |
| frame_err | output | 1 | Stop-bit error, valid with data_rdy |
| asleep | output | 1 | Receiver is asleep |

## Verification
The assertions take for granted that `nine_bit`, `wake_addr`, `idle_long`, `loop_en` and `rx_src` change only while the selected line sits high between frames. The checks relate the delivered data width to the previous cycle's format bit. The stimulus therefore changes configuration only after the line has rested high for several bit times, and it holds `samp_en` high on every clock so that bit times are exact multiples of 16 cycles. Serial levels are driven on falling clock edges and held for whole bit times. The only exceptions are deliberate single-sample glitches and a short start pulse used to probe the vote.

// File: rtl/uwr_pkg.sv
package uwr_pkg;
   typedef enum logic [1:0] {
      STB_DATA = 2'd0,
      STB_STOP = 2'd1,
      STB_IDLE = 2'd2
   } stb_kind_t;

   localparam int MAX_DATA_BITS = 9;
   localparam int FRAME_OVERHEAD = 2;
endpackage

// File: rtl/uwr_src_sel.sv
module uwr_src_sel #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_pin,
   input  logic tx_pin,
   input  logic tx_int,
   input  logic loop_en,
   input  logic rx_src,
   output logic line
);
   logic raw;

   always_comb begin
      if (!loop_en)    raw = rx_pin;
      else if (rx_src) raw = tx_pin;
      else             raw = tx_int;
   end

   generate
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
      if (SYNC_STAGES == 0) begin : g_direct
         assign line = raw;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], raw} & ((SYNC_STAGES == 1) ? {SYNC_STAGES{1'b1}} : {SYNC_STAGES{1'b1}});
         end
         assign line = chain[SYNC_STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/uwr_frame_rx.sv
module uwr_frame_rx
   import uwr_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      samp_en,
   input  logic      line,
   input  logic      nine_bit,
   output logic      bit_stb,
   output logic      bit_val,
   output stb_kind_t bit_kind,
   output logic      start_ok,
   output logic      frm_done,
   output logic      frm_ferr,
   output logic [MAX_DATA_BITS-1:0] frm_data
);
   localparam int PH_W = $clog2(OVS);
   localparam int V0   = OVS / 2 - 2;
   localparam int V1   = OVS / 2 - 1;
   localparam int V2   = OVS / 2;
   localparam int IDX_W = $clog2(MAX_DATA_BITS + FRAME_OVERHEAD + 1);

   generate
      if (OVS < 8 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("OVS must be even and at least 8");
      end
   endgenerate

   logic [PH_W-1:0]          ph;
   logic [IDX_W-1:0]         bidx;
   logic [1:0]               votes;
   logic [MAX_DATA_BITS-1:0] shreg;
   logic                     in_frame;
   logic                     armed;

   logic             maj;
   logic [IDX_W-1:0] stop_idx;
   logic             at_dec;
   logic             start_det;
   logic             ph_last;

   assign maj       = (votes[0] & votes[1]) | (votes[0] & line) | (votes[1] & line);
   assign stop_idx  = nine_bit ? IDX_W'(MAX_DATA_BITS + 1) : IDX_W'(MAX_DATA_BITS);
   assign at_dec    = samp_en && in_frame && (ph == PH_W'(V2));
   assign start_det = samp_en && !in_frame && armed && !line;
   assign ph_last   = (ph == PH_W'(OVS - 1));

   assign start_ok = at_dec && (bidx == '0) && !maj;
   assign frm_done = at_dec && (bidx == stop_idx);
   assign frm_ferr = !maj;
   assign frm_data = nine_bit ? shreg : {1'b0, shreg[MAX_DATA_BITS-1:1]};

   assign bit_stb  = (at_dec && (bidx != '0)) ||
                     (samp_en && !in_frame && ph_last && !start_det);
   assign bit_val  = in_frame ? maj : line;
   assign bit_kind = !in_frame ? STB_IDLE :
                     ((bidx == stop_idx) ? STB_STOP : STB_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame <= 1'b0;
         ph       <= '0;
         bidx     <= '0;
         votes    <= 2'b11;
         shreg    <= '0;
         armed    <= 1'b0;
      end else if (samp_en) begin
         if (!in_frame) begin
            if (start_det) begin
               in_frame <= 1'b1;
               ph       <= PH_W'(1);
               bidx     <= '0;
            end else begin
               ph <= ph_last ? '0 : ph + PH_W'(1);
               if (line) armed <= 1'b1;
            end
         end else begin
            if (ph == PH_W'(V0)) votes[0] <= line;
            if (ph == PH_W'(V1)) votes[1] <= line;
            if (at_dec) begin
               if (bidx == '0 && maj) begin
                  in_frame <= 1'b0;
                  ph       <= '0;
               end else if (bidx == stop_idx) begin
                  in_frame <= 1'b0;
                  ph       <= '0;
                  armed    <= maj;
               end else begin
                  if (bidx != '0) shreg <= {maj, shreg[MAX_DATA_BITS-1:1]};
                  ph <= ph + PH_W'(1);
               end
            end else if (ph_last) begin
               ph   <= '0;
               bidx <= bidx + IDX_W'(1);
            end else begin
               ph <= ph + PH_W'(1);
            end
         end
      end
   end

   AST_BIT_INDEX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      in_frame |-> (bidx <= IDX_W'(MAX_DATA_BITS + 1))); // R5

   AST_START_NOISE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (at_dec && bidx == '0 && maj) |=> !in_frame); // R6
endmodule

// File: rtl/uwr_idle_det.sv
module uwr_idle_det
   import uwr_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      bit_stb,
   input  logic      bit_val,
   input  stb_kind_t bit_kind,
   input  logic      start_ok,
   input  logic      idle_long,
   input  logic      nine_bit,
   output logic      idle_pulse
);
   localparam int CHAR_SHORT = MAX_DATA_BITS - 1 + FRAME_OVERHEAD;
   localparam int CHAR_LONG  = MAX_DATA_BITS + FRAME_OVERHEAD;
   localparam int CNT_W      = $clog2(CHAR_LONG + 1);

   logic [CNT_W-1:0] cnt;
   logic             armed;
   logic [CNT_W-1:0] target;
   logic             clear_cnt;
   logic             hit;

   assign target    = nine_bit ? CNT_W'(CHAR_LONG) : CNT_W'(CHAR_SHORT);
   assign clear_cnt = !bit_val || (idle_long && bit_kind != STB_IDLE);
   assign hit       = bit_stb && !clear_cnt && armed && (cnt + CNT_W'(1) == target);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt        <= '0;
         armed      <= 1'b0;
         idle_pulse <= 1'b0;
      end else begin
         idle_pulse <= hit;
         if (start_ok) begin
            cnt   <= '0;
            armed <= 1'b1;
         end else if (bit_stb) begin
            if (clear_cnt)          cnt <= '0;
            else if (cnt != target) cnt <= cnt + CNT_W'(1);
            if (hit) armed <= 1'b0;
         end
      end
   end

   AST_IDLE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      idle_pulse |=> !idle_pulse); // R8

   AST_IDLE_AFTER_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      idle_pulse |-> $past(bit_stb && bit_val)); // R9
endmodule

// File: rtl/uwr_rx_wake.sv
module uwr_rx_wake
   import uwr_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       samp_en,
   input  logic       rx_pin,
   input  logic       tx_pin,
   input  logic       tx_int,
   input  logic       loop_en,
   input  logic       rx_src,
   input  logic       nine_bit,
   input  logic       wake_addr,
   input  logic       idle_long,
   input  logic       sleep_req,
   output logic [8:0] rx_data,
   output logic       data_rdy,
   output logic       idle_det,
   output logic       frame_err,
   output logic       asleep
);
   logic                     line;
   logic                     bit_stb;
   logic                     bit_val;
   stb_kind_t                bit_kind;
   logic                     start_ok;
   logic                     frm_done;
   logic                     frm_ferr;
   logic [MAX_DATA_BITS-1:0] frm_data;
   logic                     idle_pulse;
   logic                     last_bit;
   logic                     addr_mark;
   logic                     deliver;

   uwr_src_sel #(.SYNC_STAGES(SYNC_STAGES)) i_src (
      .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .tx_pin(tx_pin),
      .tx_int(tx_int), .loop_en(loop_en), .rx_src(rx_src), .line(line)
   );

   uwr_frame_rx #(.OVS(OVS)) i_frame (
      .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .line(line),
      .nine_bit(nine_bit), .bit_stb(bit_stb), .bit_val(bit_val),
      .bit_kind(bit_kind), .start_ok(start_ok), .frm_done(frm_done),
      .frm_ferr(frm_ferr), .frm_data(frm_data)
   );

   uwr_idle_det i_idle (
      .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
      .bit_kind(bit_kind), .start_ok(start_ok), .idle_long(idle_long),
      .nine_bit(nine_bit), .idle_pulse(idle_pulse)
   );

   assign last_bit  = nine_bit ? frm_data[8] : frm_data[7];
   assign addr_mark = frm_done && wake_addr && last_bit;
   assign deliver   = frm_done && (!asleep || addr_mark);
   assign idle_det  = idle_pulse;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data   <= '0;
         data_rdy  <= 1'b0;
         frame_err <= 1'b0;
         asleep    <= 1'b0;
      end else begin
         data_rdy  <= deliver;
         frame_err <= deliver && frm_ferr;
         if (deliver) rx_data <= frm_data;
         if (sleep_req)
            asleep <= 1'b1;
         else if (asleep && ((!wake_addr && idle_pulse) || addr_mark))
            asleep <= 1'b0;
      end
   end

   AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rdy && $past(asleep)) |-> $past(wake_addr)); // R10

   AST_FERR_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |-> data_rdy); // R7

   AST_NARROW_MSB: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rdy && !$past(nine_bit)) |-> !rx_data[8]); // R4

   AST_WAKE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(asleep) |-> ($past(wake_addr) ? $past(frm_done) : $past(idle_pulse))); // R11

   AST_ADDR_WAKE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(asleep) && $past(wake_addr)) |-> (data_rdy && (rx_data[8] || rx_data[7]))); // R12
endmodule

// File: tb/test_uwr_rx_wake.sv
module test_uwr_rx_wake;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       samp_en = 1'b1;
   logic       rx_pin = 1'b1, tx_pin = 1'b1, tx_int = 1'b1;
   logic       loop_en = 1'b0, rx_src = 1'b0, nine_bit = 1'b0;
   logic       wake_addr = 1'b0, idle_long = 1'b0, sleep_req = 1'b0;
   logic [8:0] rx_data;
   logic       data_rdy, idle_det, frame_err, asleep;

   int checks = 0, failures = 0;
   int cyc = 0, rdy_cnt = 0, idle_cnt = 0, rdy_cyc = 0, idle_cyc = 0;
   logic [8:0] last_data = '0;
   logic       last_ferr = 1'b0;

   always #10 clk = ~clk;

   uwr_rx_wake i_uwr_rx_wake (
      .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .rx_pin(rx_pin),
      .tx_pin(tx_pin), .tx_int(tx_int), .loop_en(loop_en), .rx_src(rx_src),
      .nine_bit(nine_bit), .wake_addr(wake_addr), .idle_long(idle_long),
      .sleep_req(sleep_req), .rx_data(rx_data), .data_rdy(data_rdy),
      .idle_det(idle_det), .frame_err(frame_err), .asleep(asleep)
   );

   always @(negedge clk) begin
      cyc++;
      if (data_rdy) begin
         rdy_cnt++;
         last_data = rx_data;
         last_ferr = frame_err;
         rdy_cyc   = cyc;
      end
      if (idle_det) begin
         idle_cnt++;
         idle_cyc = cyc;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic set_line(input int w, input logic v);
      case (w)
         0:       rx_pin = v;
         1:       tx_pin = v;
         default: tx_int = v;
      endcase
   endtask

   task automatic wait_bits(input int n);
      repeat (n * 16) @(negedge clk);
   endtask

   task automatic send(input int w, input logic [8:0] d, input int nb,
                       input logic stp, input int glitch_bit);
      for (int b = 0; b <= nb + 1; b++) begin
         logic v;
         v = (b == 0) ? 1'b0 : ((b == nb + 1) ? stp : d[b-1]);
         for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            set_line(w, (b == glitch_bit && c == 7) ? ~v : v);
         end
      end
      @(negedge clk);
      set_line(w, 1'b1);
      wait_bits(1);
   endtask

   task automatic expect_char(input string tag, input int r0, input logic [8:0] d,
                              input logic fe);
      chk(rdy_cnt == r0 + 1, tag, rdy_cnt - r0, 1);
      chk(last_data == d, tag, last_data, d);
      chk(last_ferr == fe, tag, last_ferr, fe);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int r0, i0;
      logic [8:0] v;
      repeat (5) @(negedge clk);
      // R13 reset state
      chk(data_rdy == 0 && idle_det == 0 && frame_err == 0, "R13 flags", data_rdy, 0);
      chk(asleep == 0, "R13 asleep", asleep, 0);
      chk(rx_data == 0, "R13 data", rx_data, 0);
      rst_n = 1'b1;
      wait_bits(2);

      // R1 R4: every byte on rx_pin, other sources held low
      tx_pin = 1'b0; tx_int = 1'b0;
      for (int b = 0; b < 256; b++) begin
         r0 = rdy_cnt;
         send(0, 9'(b), 8, 1'b1, -1);
         expect_char("R4 R1 byte", r0, 9'(b), 1'b0);
      end
      tx_pin = 1'b1; tx_int = 1'b1;
      wait_bits(12);

      // R5: nine-bit characters
      nine_bit = 1'b1;
      wait_bits(1);
      for (int i = 0; i < 64; i++) begin
         v = 9'((i * 37 + 5) & 9'h1FF);
         if (i == 0) v = 9'h100;
         if (i == 1) v = 9'h1FF;
         r0 = rdy_cnt;
         send(0, v, 9, 1'b1, -1);
         expect_char("R5 nine", r0, v, 1'b0);
      end
      nine_bit = 1'b0;
      wait_bits(12);

      // R6: single glitch on a vote sample, and a short start pulse
      r0 = rdy_cnt;
      send(0, 9'h0A5, 8, 1'b1, 1);
      expect_char("R6 glitch d0", r0, 9'h0A5, 1'b0);
      r0 = rdy_cnt;
      send(0, 9'h0A5, 8, 1'b1, 4);
      expect_char("R6 glitch d3", r0, 9'h0A5, 1'b0);
      r0 = rdy_cnt;
      @(negedge clk); rx_pin = 1'b0;
      repeat (3) @(negedge clk);
      rx_pin = 1'b1;
      wait_bits(14);
      chk(rdy_cnt == r0, "R6 noise start", rdy_cnt - r0, 0);

      // R7: framing error then a clean frame
      r0 = rdy_cnt;
      send(0, 9'h055, 8, 1'b0, -1);
      expect_char("R7 ferr", r0, 9'h055, 1'b1);
      r0 = rdy_cnt;
      send(0, 9'h0C3, 8, 1'b1, -1);
      expect_char("R7 clean", r0, 9'h0C3, 1'b0);
      wait_bits(12);

      // R2: internal loop, both pins stuck low
      loop_en = 1'b1; rx_src = 1'b0;
      rx_pin = 1'b0; tx_pin = 1'b0;
      r0 = rdy_cnt;
      send(2, 9'h0A5, 8, 1'b1, -1);
      expect_char("R2 loop", r0, 9'h0A5, 1'b0);
      rx_pin = 1'b1; tx_pin = 1'b1;
      wait_bits(12);
      // R3: single wire on tx_pin
      rx_src = 1'b1;
      rx_pin = 1'b0; tx_int = 1'b0;
      r0 = rdy_cnt;
      send(1, 9'h03C, 8, 1'b1, -1);
      expect_char("R3 wire", r0, 9'h03C, 1'b0);
      rx_pin = 1'b1; tx_int = 1'b1;
      wait_bits(12);
      loop_en = 1'b0; rx_src = 1'b0;
      wait_bits(2);

      // R8 short idle: 0x80 leaves two ones, 8 more bit times needed
      i0 = idle_cnt;
      send(0, 9'h080, 8, 1'b1, -1);
      wait_bits(14);
      chk(idle_cnt == i0 + 1, "R8 once", idle_cnt - i0, 1);
      chk(idle_cyc - rdy_cyc == 128, "R8 short 80", idle_cyc - rdy_cyc, 128);
      i0 = idle_cnt;
      send(0, 9'h0FF, 8, 1'b1, -1);
      wait_bits(14);
      chk(idle_cyc - rdy_cyc == 16, "R8 short FF", idle_cyc - rdy_cyc, 16);
      chk(idle_cnt == i0 + 1, "R8 single", idle_cnt - i0, 1);
      nine_bit = 1'b1;
      wait_bits(1);
      send(0, 9'h1FF, 9, 1'b1, -1);
      wait_bits(14);
      chk(idle_cyc - rdy_cyc == 16, "R8 short nine", idle_cyc - rdy_cyc, 16);

      // R9 long idle
      idle_long = 1'b1;
      wait_bits(1);
      send(0, 9'h1FF, 9, 1'b1, -1);
      wait_bits(14);
      chk(idle_cyc - rdy_cyc == 176, "R9 long nine", idle_cyc - rdy_cyc, 176);
      nine_bit = 1'b0;
      wait_bits(1);
      send(0, 9'h0FF, 8, 1'b1, -1);
      wait_bits(14);
      chk(idle_cyc - rdy_cyc == 160, "R9 long eight", idle_cyc - rdy_cyc, 160);
      idle_long = 1'b0;
      wait_bits(2);

      // R10 R11: idle wake-up
      wake_addr = 1'b0;
      @(negedge clk); sleep_req = 1'b1;
      @(negedge clk); sleep_req = 1'b0;
      chk(asleep == 1, "R10 set", asleep, 1);
      r0 = rdy_cnt;
      send(0, 9'h03C, 8, 1'b1, -1);
      chk(rdy_cnt == r0, "R10 muted", rdy_cnt - r0, 0);
      wait_bits(12);
      chk(asleep == 0, "R11 idle wake", asleep, 0);
      r0 = rdy_cnt;
      send(0, 9'h05A, 8, 1'b1, -1);
      expect_char("R11 after wake", r0, 9'h05A, 1'b0);
      wait_bits(12);

      // R12: address mark wake-up, 8-bit
      wake_addr = 1'b1;
      @(negedge clk); sleep_req = 1'b1;
      @(negedge clk); sleep_req = 1'b0;
      r0 = rdy_cnt;
      send(0, 9'h005, 8, 1'b1, -1);
      chk(rdy_cnt == r0, "R12 no mark", rdy_cnt - r0, 0);
      wait_bits(12);
      chk(asleep == 1, "R12 idle ignored", asleep, 1);
      r0 = rdy_cnt;
      send(0, 9'h085, 8, 1'b1, -1);
      expect_char("R12 mark", r0, 9'h085, 1'b0);
      chk(asleep == 0, "R12 awake", asleep, 0);
      wait_bits(12);

      // R12: address mark in 9-bit format
      nine_bit = 1'b1;
      wait_bits(1);
      @(negedge clk); sleep_req = 1'b1;
      @(negedge clk); sleep_req = 1'b0;
      r0 = rdy_cnt;
      send(0, 9'h0FF, 9, 1'b1, -1);
      chk(rdy_cnt == r0 && asleep == 1, "R12 nine no mark", rdy_cnt - r0, 0);
      r0 = rdy_cnt;
      send(0, 9'h101, 9, 1'b1, -1);
      expect_char("R12 nine mark", r0, 9'h101, 1'b0);
      chk(asleep == 0, "R12 nine awake", asleep, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule